// File: doc/BRIEF.md
# Montgomery Ladder Step Sequencer

This control unit walks a secret scalar of `KEY_W` bits from its top bit down to bit 0 and drives one combined double-and-add request per bit to an external point datapath. Each request is a one-cycle `op_start` pulse, and the unit waits for a one-cycle `op_done` reply before it moves on. The field arithmetic and the point memories sit outside this block.

The two working-point registers are never copied. A one-bit role pointer, `role_sel`, tells the datapath which physical register currently plays the accumulator role (V1) and which plays the companion role (V2). With `role_sel` = 0, register 0 is V1 and register 1 is V2; with `role_sel` = 1 they are exchanged. Register 0 is loaded with the fixed constant point and register 1 with the base point.

The two conditional swaps that surround every ladder step are folded into one swap between steps, controlled by the XOR of two neighbouring key bits:
- When a run is accepted, the pointer is set from the pair (0, top bit).
- After each step the pointer toggles by the XOR of the current bit and the next lower bit.
- After the last step it toggles by bit 0, since the bit below bit 0 is taken as 0.

The toggle always falls in the same cycle of a step, so the timing does not depend on the key. `KEY_W` must be at least 2.

Top module: `ladder_seq`

## Requirements
- R1: After reset, `busy`, `done`, `op_start` and `role_sel` are 0 and `step_idx` is 0.
- R2: A `start` sampled while idle raises `busy` and `op_start` in the next cycle; `op_start` is high for exactly one cycle per step.
- R3: One run issues exactly `KEY_W` `op_start` pulses, with `step_idx` reading `KEY_W-1`, `KEY_W-2`, ..., 0 during those pulses, one value per pulse in that order.
- R4: While `op_start` is high for step i, `role_sel` equals key bit i (1 = register 1 holds V1).
- R5: `role_sel` changes only at the clock edge that accepts a run or at the edge that samples `op_done` while waiting on a step; it holds at every other edge.
- R6: The unit waits for `op_done` for as long as the datapath takes. The next `op_start` is raised in the cycle right after the edge that samples `op_done`, so with a datapath that answers L cycles after `op_start`, the pulses are L+1 cycles apart.
- R7: In the cycle right after the last `op_done` is sampled, `done` is high for one cycle and `role_sel` is 0. In the cycle after that, `busy` is 0.
- R8: A `start` arriving while `busy` is 1 is ignored: the step order, the pulse count, the role values and the run length all stay those of the scalar latched at acceptance.
- R9: With a datapath latency of L cycles, `done` is seen `KEY_W`*(L+1)+1 cycles after the cycle in which `start` was presented, for every key value.
- R10: An `op_done` pulse while idle has no effect: `busy`, `op_start`, `done` and `role_sel` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a new ladder run (honoured only while idle) |
| scalar | input | KEY_W | Secret scalar, latched when `start` is accepted |
| busy | output | 1 | High from acceptance through the `done` cycle |
| done | output | 1 | One-cycle pulse when the ladder finishes |
| op_start | output | 1 | One-cycle request for a double-and-add step |
| op_done | input | 1 | One-cycle completion reply from the datapath |
| role_sel | output | 1 | 0: register 0 is V1; 1: register 1 is V1 |
| step_idx | output | $clog2(KEY_W) | Index of the key bit of the current step |

## Verification
The first `op_start` and `busy` are due one cycle after `start` is sampled. Every later `op_start` is due one cycle after the edge that takes `op_done`, `done` one cycle after the last such edge, and the drop of `busy` one cycle after `done`. The bench drives inputs and samples outputs at falling edges, and a monitor samples shortly after each falling edge. The stand-in datapath answers exactly L cycles after each request, so the bench checks the pulse spacing of L+1 and the total of `KEY_W`*(L+1)+1 cycles as exact numbers. It also checks that `role_sel` equals the key bit at every pulse and changes only at the edges R5 allows.

// File: rtl/ladder_pkg.sv
package ladder_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_FIN   = 2'd3
  } lad_state_e;

  // Merged swap control: two neighbouring conditional swaps collapse to one
  // exchange exactly when their control bits differ.
  function automatic logic merge_swap(input logic cur_bit, input logic nxt_bit);
    return cur_bit ^ nxt_bit;
  endfunction

endpackage

// File: rtl/ladder_keyreg.sv
module ladder_keyreg #(
  parameter int KEY_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [KEY_W-1:0] scalar,
  input  logic             shift,
  output logic             bit_cur,
  output logic             bit_nxt
);

  logic [KEY_W-1:0] key_sh;

  // Zeros shift in from below, so after bit 0 the "next" bit reads 0.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     key_sh <= '0;
    else if (load)  key_sh <= scalar;
    else if (shift) key_sh <= {key_sh[KEY_W-2:0], 1'b0};
  end

  assign bit_cur = key_sh[KEY_W-1];
  assign bit_nxt = key_sh[KEY_W-2];

endmodule

// File: rtl/ladder_role.sv
module ladder_role
  import ladder_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic load_top,
  input  logic advance,
  input  logic bit_cur,
  input  logic bit_nxt,
  output logic role,
  output logic swap_ev
);

  assign swap_ev = advance & merge_swap(bit_cur, bit_nxt);

  // The pointer is the only thing that moves; the point data stays in place.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       role <= 1'b0;
    else if (load)    role <= merge_swap(1'b0, load_top);
    else if (swap_ev) role <= ~role;
  end

endmodule

// File: rtl/ladder_fsm.sv
module ladder_fsm
  import ladder_pkg::*;
#(
  parameter int KEY_W = 128,
  localparam int IDX_W = $clog2(KEY_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             op_done,
  output logic [IDX_W-1:0] step_idx,
  output logic             load,
  output logic             advance,
  output logic             op_start,
  output logic             busy,
  output logic             done
);

  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(KEY_W - 1);

  lad_state_e state, state_nx;
  logic       last_step;

  assign last_step = (step_idx == '0);
  assign load      = (state == ST_IDLE) && start;
  assign advance   = (state == ST_WAIT) && op_done;
  assign op_start  = (state == ST_ISSUE);
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_FIN);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (start) state_nx = ST_ISSUE;
      ST_ISSUE: state_nx = ST_WAIT;
      ST_WAIT:  if (op_done) state_nx = last_step ? ST_FIN : ST_ISSUE;
      ST_FIN:   state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      step_idx <= '0;
    end else begin
      state <= state_nx;
      if (load)                       step_idx <= IDX_TOP;
      else if (advance && !last_step) step_idx <= step_idx - IDX_W'(1);
    end
  end

  AST_OPSTART_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> !op_start); // R2
  AST_IDX_DESCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !last_step) |=> (step_idx == $past(step_idx) - IDX_W'(1))); // R3
  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && !op_done) |=> (state == ST_WAIT)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy)); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !op_done) |=> $stable(step_idx)); // R8

endmodule

// File: rtl/ladder_seq.sv
module ladder_seq
  import ladder_pkg::*;
#(
  parameter int KEY_W = 128,
  localparam int IDX_W = $clog2(KEY_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [KEY_W-1:0] scalar,
  output logic             busy,
  output logic             done,
  output logic             op_start,
  input  logic             op_done,
  output logic             role_sel,
  output logic [IDX_W-1:0] step_idx
);

  logic load_ev;
  logic advance_ev;
  logic key_cur;
  logic key_nxt;
  logic swap_ev;

  ladder_fsm #(.KEY_W(KEY_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .op_done  (op_done),
    .step_idx (step_idx),
    .load     (load_ev),
    .advance  (advance_ev),
    .op_start (op_start),
    .busy     (busy),
    .done     (done)
  );

  ladder_keyreg #(.KEY_W(KEY_W)) u_key (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load_ev),
    .scalar  (scalar),
    .shift   (advance_ev),
    .bit_cur (key_cur),
    .bit_nxt (key_nxt)
  );

  ladder_role u_role (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_ev),
    .load_top (scalar[KEY_W-1]),
    .advance  (advance_ev),
    .bit_cur  (key_cur),
    .bit_nxt  (key_nxt),
    .role     (role_sel),
    .swap_ev  (swap_ev)
  );

  AST_ROLE_TRACKS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> (role_sel == key_cur)); // R4
  AST_ROLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_ev && !advance_ev) |=> $stable(role_sel)); // R5
  AST_ROLE_RESTORED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !role_sel); // R7
  AST_NO_SWAP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !swap_ev); // R10

endmodule

// File: tb/ladder_seq_tb_top.sv
module ladder_seq_tb_top;

  localparam int KW = 128;
  localparam int IW = $clog2(KW);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [KW-1:0] scalar = '0;
  logic          busy, done, op_start, role_sel;
  logic          op_done;
  logic [IW-1:0] step_idx;

  logic sd_done = 1'b0;
  logic extra_done = 1'b0;
  assign op_done = sd_done | extra_done;

  always #5 clk = ~clk;

  ladder_seq #(.KEY_W(KW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .scalar(scalar),
    .busy(busy), .done(done), .op_start(op_start), .op_done(op_done),
    .role_sel(role_sel), .step_idx(step_idx)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int lat_cfg = 1;
  logic [KW-1:0] cur_key = '0;

  // monitor results
  int n_ops, idx_err, role_err, hold_err, gap_err, last_op, exp_idx;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Stand-in datapath: answers lat_cfg cycles after each request.
  initial begin
    int cnt;
    cnt = 0;
    forever begin
      @(negedge clk);
      if (cnt != 0) begin
        cnt--;
        sd_done = (cnt == 0);
      end else begin
        sd_done = 1'b0;
      end
      if (op_start) cnt = lat_cfg;
    end
  end

  // Monitor sampling shortly after each falling edge.
  initial begin
    logic p_role, p_done, p_start, p_busy;
    p_role = 0; p_done = 0; p_start = 0; p_busy = 0;
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        if (op_start) begin
          if (int'(step_idx) != exp_idx) idx_err++;
          if (role_sel != cur_key[step_idx]) role_err++;
          if (n_ops > 0 && (cyc - last_op) != lat_cfg + 1) gap_err++;
          last_op = cyc;
          n_ops++;
          exp_idx--;
        end
        if (role_sel != p_role && !p_done && !(p_start && !p_busy)) hold_err++;
      end
      p_role = role_sel; p_done = op_done; p_start = start; p_busy = busy;
    end
  end

  task automatic test_reset();
    @(negedge clk);
    check(busy == 0 && done == 0 && op_start == 0, "R1 ctrl", {busy, done, op_start}, 0);
    check(role_sel == 0, "R1 role", role_sel, 0);
    check(step_idx == 0, "R1 idx", int'(step_idx), 0);
  endtask

  task automatic run_ladder(input logic [KW-1:0] key, input int lat, input bit inject, input string name);
    int c0, elapsed, limit;
    cur_key = key; lat_cfg = lat;
    n_ops = 0; idx_err = 0; role_err = 0; hold_err = 0; gap_err = 0; exp_idx = KW - 1; last_op = 0;
    @(negedge clk);
    scalar = key; start = 1'b1; c0 = cyc;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1 && op_start == 1, {"R2 accept ", name}, {busy, op_start}, 3);
    @(negedge clk);
    check(op_start == 0, {"R2 pulse width ", name}, op_start, 0);
    if (inject) begin
      repeat (4) @(negedge clk);
      scalar = ~key; start = 1'b1;
      repeat (3) @(negedge clk);
      start = 1'b0; scalar = key;
    end
    limit = KW * (lat + 1) + 10;
    while (!done && (cyc - c0) < limit) @(negedge clk);
    elapsed = cyc - c0;
    check(done == 1 && role_sel == 0, {"R7 done/role ", name}, {done, role_sel}, 2);
    check(elapsed == KW * (lat + 1) + 1, {"R9 run length ", name}, elapsed, KW * (lat + 1) + 1);
    @(negedge clk);
    check(done == 0 && busy == 0, {"R7 end ", name}, {done, busy}, 0);
    #2;
    check(n_ops == KW, {"R3 pulses ", name}, n_ops, KW);
    check(idx_err == 0, {"R3 index order ", name}, idx_err, 0);
    check(role_err == 0, {"R4 role vs key ", name}, role_err, 0);
    check(hold_err == 0, {"R5 role hold ", name}, hold_err, 0);
    check(gap_err == 0, {"R6 spacing ", name}, gap_err, 0);
    if (inject) check(role_err == 0 && n_ops == KW, {"R8 start ignored ", name}, n_ops, KW);
  endtask

  task automatic test_idle_done();
    @(negedge clk);
    extra_done = 1'b1;
    @(negedge clk);
    extra_done = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check(busy == 0 && op_start == 0 && done == 0 && role_sel == 0, "R10 idle op_done",
            {busy, op_start, done, role_sel}, 0);
    end
  endtask

  task automatic finish_report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    run_ladder('0, 1, 1'b0, "zeros");
    run_ladder('1, 1, 1'b0, "ones");
    run_ladder({(KW/2){2'b10}}, 2, 1'b0, "alternate");
    run_ladder({1'b1, {(KW-1){1'b0}}}, 3, 1'b0, "top only");
    run_ladder({{(KW-1){1'b0}}, 1'b1}, 1, 1'b0, "bottom only");
    run_ladder({4{32'h9e37_79b9}} ^ {KW{1'b0}}, 4, 1'b1, "mixed inject");
    run_ladder({64'h0123_4567_89ab_cdef, 64'hf0e1_d2c3_b4a5_9687}, 2, 1'b0, "mixed");
    test_idle_done();
    finish_report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    finish_report();
  end

endmodule